// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Full Policy

This block sits between a source of three-axis motion samples and a register read port. Each accepted sample carries one X, one Y and one Z word. The three words are stored as a single entry and popped as a single entry, so the axes of one sample never come apart. A 2-bit mode input sets what the buffer does when it fills:

- drop new samples and stop collecting;
- overwrite the oldest entry;
- overwrite until a trigger arrives, then stop.

A fourth mode turns storage off. In that mode only a set of holding registers follows the most recent sample.

Samples enter on a valid/ready port. The source is a free-running converter that cannot be stalled, so `in_ready` is low only during the single cycle in which a new mode value is taken in. A full buffer never back-pressures; the selected full policy decides what happens to the sample. Entries leave on a valid/ready port: `out_valid` is high while the buffer holds data in a storing mode, and each cycle with `out_valid` and `out_ready` both high pops one entry. Burst reads are consecutive cycles with `out_ready` held high. Status outputs give the fill count, empty, full, overrun and a gated watermark flag.

Top module: `triaxis_fifo`

## Requirements
- R1: After reset the fill count is 0, `empty` is 1, `full`, `overrun`, `watermark` and `out_valid` are 0, the holding registers read 0, and the active mode is bypass (code 00).
- R2: Mode codes are 00 bypass, 01 stop-when-full, 10 overwrite-oldest, 11 overwrite-then-stop on trigger. In bypass nothing is stored: the count stays 0 and `out_valid` stays 0. In every mode, the holding outputs show the last sample accepted with `in_valid` and `in_ready` high, from the cycle after it is accepted.
- R3: Popped entries come out in arrival order. `out_x`, `out_y` and `out_z` show the oldest entry's three words together whenever `out_valid` is high.
- R4: In mode 01, a sample that arrives while the count is DEPTH (32) is discarded and the stored contents stay unchanged.
- R5: In mode 01, once the count has been DEPTH, all further samples are discarded until a new mode value is written, even after pops have freed space.
- R6: In mode 10, a sample that arrives while the buffer is full and no pop occurs replaces the oldest entry. The count stays DEPTH, and the next-oldest entry becomes the head.
- R7: In mode 10 with a full buffer, a push and a pop in the same cycle leave the count at DEPTH, and the popped data is the entry that was oldest before the push.
- R8: In mode 11, the buffer follows mode 10 rules until `trig` is sampled high on a clock edge. From the next cycle on it follows mode 01 rules, including the stop after reaching full.
- R9: `watermark` is high exactly when `wm_en` is 1 and the count is greater than or equal to `wm_level`.
- R10: `overrun` sets in the cycle after a sample is discarded or overwrites an entry because the buffer is full, and clears in the cycle after any pop. A pop takes precedence over a loss in the same cycle.
- R11: A cycle in which `mode_sel` differs from the active mode loads the new mode and clears the count, the pointers, the latched trigger, the stop state and `overrun`. In that cycle `in_ready` and `out_valid` are 0 and no push or pop happens.
- R12: `in_ready` is 1 in every cycle except a mode-change cycle. `out_valid` is 1 exactly when the mode is not bypass, no mode change is pending, and the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Requested buffer mode |
| trig | input | 1 | Trigger event for mode 11 |
| wm_level | input | 5 | Watermark fill level |
| wm_en | input | 1 | Watermark output enable |
| in_valid | input | 1 | Sample present on in_x/in_y/in_z |
| in_ready | output | 1 | Sample accepted this cycle when valid |
| in_x | input | 10 | Incoming X word |
| in_y | input | 10 | Incoming Y word |
| in_z | input | 10 | Incoming Z word |
| out_valid | output | 1 | An entry is available to pop |
| out_ready | input | 1 | Reader pops the head entry |
| out_x | output | 10 | Oldest entry, X word |
| out_y | output | 10 | Oldest entry, Y word |
| out_z | output | 10 | Oldest entry, Z word |
| hold_x | output | 10 | Latest accepted X word |
| hold_y | output | 10 | Latest accepted Y word |
| hold_z | output | 10 | Latest accepted Z word |
| count | output | 6 | Current fill count |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals depth |
| overrun | output | 1 | A sample was lost since the last pop |
| watermark | output | 1 | Gated fill-level flag |

## Verification
The bench uses the default depth of 32 and 10-bit words. At that size a run of continuous pushes reaches full within about 32 cycles, so the drop, overwrite, stop and trigger paths come up many times per mode, both in the directed sequences and in the random phase. The random phase changes mode rarely and pops at varied rates. This lets the fill level wander across the whole range and through pointer wrap, and lets the watermark level sweep all 32 values. It also puts mode changes at arbitrary fill levels, including full, and at arbitrary trigger states.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_HALT   = 2'b01,
    MODE_RING   = 2'b10,
    MODE_TRIG   = 2'b11
  } fifo_mode_e;
endpackage

// File: rtl/tfifo_mem.sv
module tfifo_mem #(
  parameter int WIDTH = 30,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          trig_i,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          accept,
  output logic          avail,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          overrun_o
);
  fifo_mode_e    mode_q;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          trig_q, halt_q, ovr_q;

  logic mode_chg, active, pop, push_try, fifo_like, is_full, drop, ovw;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    mode_chg  = (mode_i != mode_q);
    active    = !mode_chg && (mode_q != MODE_BYPASS);
    is_full   = (cnt == CW'(DEPTH));
    pop       = active && pop_req && (cnt != '0);
    push_try  = active && push_req;
    fifo_like = (mode_q == MODE_HALT) || ((mode_q == MODE_TRIG) && trig_q);
    drop      = push_try && fifo_like && (halt_q || is_full);
    ovw       = push_try && !fifo_like && is_full && !pop;
    wr_en     = push_try && !drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BYPASS;
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      trig_q <= 1'b0;
      halt_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= fifo_mode_e'(mode_i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      trig_q <= 1'b0;
      halt_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (pop || ovw) rd_ptr <= bump(rd_ptr);
      if (wr_en)      wr_ptr <= bump(wr_ptr);
      if (wr_en && !pop && !ovw)   cnt <= cnt + CW'(1);
      else if (pop && !wr_en)      cnt <= cnt - CW'(1);
      if (pop)                ovr_q <= 1'b0;
      else if (drop || ovw)   ovr_q <= 1'b1;
      if (fifo_like && is_full) halt_q <= 1'b1;
      if ((mode_q == MODE_TRIG) && trig_i) trig_q <= 1'b1;
    end
  end

  assign accept    = !mode_chg;
  assign avail     = active && (cnt != '0);
  assign wr_addr   = wr_ptr;
  assign rd_addr   = rd_ptr;
  assign count_o   = cnt;
  assign full_o    = is_full;
  assign empty_o   = (cnt == '0);
  assign overrun_o = ovr_q;

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_bypass_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BYPASS) |-> (cnt == '0));

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !mode_chg && !pop) |=> $stable(cnt));

  assert_ring_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |=> (cnt == CW'(DEPTH)) && ovr_q);

  assert_dual_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && (mode_q == MODE_RING) && is_full && push_try && pop)
      |=> (cnt == CW'(DEPTH)));

  assert_pop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !ovr_q);

  assert_mode_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0) && !trig_q && !halt_q && !ovr_q);
endmodule

// File: rtl/triaxis_fifo.sv
module triaxis_fifo #(
  parameter int DEPTH = 32,
  parameter int SW    = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = 3 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          trig,
  input  logic [AW-1:0] wm_level,
  input  logic          wm_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_x,
  input  logic [SW-1:0] in_y,
  input  logic [SW-1:0] in_z,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_x,
  output logic [SW-1:0] out_y,
  output logic [SW-1:0] out_z,
  output logic [SW-1:0] hold_x,
  output logic [SW-1:0] hold_y,
  output logic [SW-1:0] hold_z,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          watermark
);
  logic [2:0][SW-1:0] in_axes, out_axes, hold_axes;
  logic               we;
  logic [AW-1:0]      waddr, raddr;
  logic [EW-1:0]      rdata;

  assign in_axes = {in_z, in_y, in_x};

  tfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_sel),
    .trig_i    (trig),
    .push_req  (in_valid),
    .pop_req   (out_ready),
    .accept    (in_ready),
    .avail     (out_valid),
    .wr_en     (we),
    .wr_addr   (waddr),
    .rd_addr   (raddr),
    .count_o   (count),
    .full_o    (full),
    .empty_o   (empty),
    .overrun_o (overrun)
  );

  tfifo_mem #(.WIDTH(EW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (in_axes),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign out_axes = rdata;

  for (genvar a = 0; a < 3; a++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hold_axes[a] <= '0;
      else if (in_valid && in_ready) hold_axes[a] <= in_axes[a];
    end
  end

  assign out_x  = out_axes[0];
  assign out_y  = out_axes[1];
  assign out_z  = out_axes[2];
  assign hold_x = hold_axes[0];
  assign hold_y = hold_axes[1];
  assign hold_z = hold_axes[2];

  assign watermark = wm_en && (count >= CW'(wm_level));

  assert_hold_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (hold_x == $past(in_x)) && (hold_z == $past(in_z)));

  assert_pop_needs_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty && in_ready);
endmodule

// File: tb/sim_triaxis_fifo.sv
module sim_triaxis_fifo;
  localparam int D = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       trig = 1'b0;
  logic [4:0] wm_level = 5'd0;
  logic       wm_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_x = '0, in_y = '0, in_z = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [9:0] out_x, out_y, out_z, hold_x, hold_y, hold_z;
  logic [5:0] count;
  logic       empty, full, overrun, watermark;

  triaxis_fifo u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [29:0] arr [D];
  int          mhead = 0, mcnt = 0;
  logic [1:0]  mmode = 2'b00;
  bit          mtrig = 0, mhalt = 0, movr = 0, last_chg = 0;
  logic [29:0] mhold = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input bit iv, input bit ordy);
    bit chg, ov;
    string ctag, dtag;
    chg = (mode_sel != mmode);
    ov  = !chg && (mmode != 2'b00) && (mcnt > 0);
    case (mmode)
      2'b00:   ctag = "R2";
      2'b01:   ctag = mhalt ? "R5" : "R4";
      2'b10:   ctag = (mcnt == D && iv && ordy) ? "R7" : "R6";
      default: ctag = "R8";
    endcase
    if (last_chg) ctag = "R11";
    dtag = (mmode == 2'b10 && mcnt == D && iv && ordy) ? "R7" : "R3";
    chk(count == 6'(mcnt), ctag, "count", count, mcnt);
    chk(empty == (mcnt == 0), ctag, "empty", empty, mcnt == 0);
    chk(full == (mcnt == D), ctag, "full", full, mcnt == D);
    chk(in_ready == !chg, "R12", "in_ready", in_ready, !chg);
    chk(out_valid == ov, "R12", "out_valid", out_valid, ov);
    if (ov) chk({out_z, out_y, out_x} == arr[mhead], dtag, "out_data",
                {out_z, out_y, out_x}, arr[mhead]);
    chk(overrun == movr, last_chg ? "R11" : "R10", "overrun", overrun, movr);
    chk(watermark == (wm_en && mcnt >= int'(wm_level)), "R9", "watermark",
        watermark, wm_en && mcnt >= int'(wm_level));
    chk({hold_z, hold_y, hold_x} == mhold, "R2", "hold", {hold_z, hold_y, hold_x}, mhold);
  endtask

  task automatic model(input logic [1:0] md, input bit tg, input bit iv,
                       input bit ordy, input logic [29:0] v);
    bit fl, full0, pop, drop, ovw;
    if (md != mmode) begin
      mmode = md; mcnt = 0; mhead = 0; mtrig = 0; mhalt = 0; movr = 0;
      last_chg = 1;
      return;
    end
    last_chg = 0;
    if (iv) mhold = v;
    if (mmode == 2'b00) return;
    fl    = (mmode == 2'b01) || (mmode == 2'b11 && mtrig);
    full0 = (mcnt == D);
    pop   = ordy && (mcnt > 0);
    drop  = 0; ovw = 0;
    if (pop) begin mhead = (mhead + 1) % D; mcnt--; end
    if (iv) begin
      if (fl && (mhalt || full0)) drop = 1;
      else if (!fl && full0 && !pop) begin
        arr[mhead] = v; mhead = (mhead + 1) % D; ovw = 1;
      end else begin
        arr[(mhead + mcnt) % D] = v; mcnt++;
      end
    end
    if (pop) movr = 0;
    else if (drop || ovw) movr = 1;
    if (fl && full0) mhalt = 1;
    if (mmode == 2'b11 && tg) mtrig = 1;
  endtask

  task automatic step(input logic [1:0] md, input bit tg, input bit iv, input bit ordy);
    logic [29:0] v;
    v = 30'($urandom);
    mode_sel = md; trig = tg; in_valid = iv; out_ready = ordy;
    {in_z, in_y, in_x} = v;
    #1;
    compare(iv, ordy);
    @(posedge clk);
    model(md, tg, iv, ordy, v);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(count == 0, "R1", "reset count", count, 0);
    chk(empty == 1, "R1", "reset empty", empty, 1);
    chk(!full && !overrun && !out_valid, "R1", "reset flags",
        {full, overrun, out_valid}, 0);
    chk({hold_z, hold_y, hold_x} == 0, "R1", "reset hold", {hold_z, hold_y, hold_x}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // bypass: nothing stored, holding registers track
    for (int i = 0; i < 6; i++) step(2'b00, 0, 1, 1);
    // stop-when-full: fill past full, then pops with pushes, then drain
    wm_en = 1; wm_level = 5'd20;
    for (int i = 0; i < 40; i++) step(2'b01, 0, 1, 0);
    for (int i = 0; i < 6; i++)  step(2'b01, 0, 1, 1);
    for (int i = 0; i < 30; i++) step(2'b01, 0, 1, 1);
    // overwrite-oldest: overfill, dual push/pop on full, partial drain
    for (int i = 0; i < 40; i++) step(2'b10, 0, 1, 0);
    for (int i = 0; i < 6; i++)  step(2'b10, 0, 1, 1);
    for (int i = 0; i < 10; i++) step(2'b10, 0, 0, 1);
    // overwrite then stop: overfill, trigger, further pushes dropped
    for (int i = 0; i < 36; i++) step(2'b11, 0, 1, 0);
    step(2'b11, 1, 1, 0);
    for (int i = 0; i < 5; i++)  step(2'b11, 0, 1, 0);
    for (int i = 0; i < 5; i++)  step(2'b11, 0, 1, 1);
    // trigger on a partly filled buffer
    for (int i = 0; i < 3; i++)  step(2'b10, 0, 1, 0);
    for (int i = 0; i < 10; i++) step(2'b11, 0, 1, 0);
    step(2'b11, 1, 1, 0);
    for (int i = 0; i < 30; i++) step(2'b11, 0, 1, ($urandom % 4) == 0);
    // mode change while full
    for (int i = 0; i < 35; i++) step(2'b10, 0, 1, 0);
    step(2'b01, 0, 1, 1);
    step(2'b01, 0, 1, 1);

    begin
      logic [1:0] md;
      int rd_pct;
      md = 2'b10; rd_pct = 50;
      for (int i = 0; i < 6000; i++) begin
        if (($urandom % 150) == 0) md = 2'($urandom);
        if (($urandom % 200) == 0) rd_pct = 10 + int'($urandom % 80);
        if (($urandom % 50) == 0) wm_level = 5'($urandom);
        if (($urandom % 300) == 0) wm_en = ~wm_en;
        step(md, ($urandom % 80) == 0, ($urandom % 10) < 7, int'($urandom % 100) < rd_pct);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule